// File: doc/BRIEF.md
# Pipelined Parallel-Prefix Adder

This block adds two unsigned operands through a four-stage register pipeline. The carries come from a log-depth parallel-prefix tree in which each bit keeps its own generate and propagate pair. Every level of the tree combines a bit with the bit a fixed span below it, and the spans double from one level to the next. The only combining gate is a two-input group operator. The adder has no carry-in. It returns the sum modulo 2^WIDTH and the carry out of the top bit.

The work is split across the stages in a fixed way:

- The first stage forms the per-bit generate and propagate signals.
- The second stage runs the lower half of the prefix levels (spans 1 and 2 at the default width).
- The third stage runs the remaining levels (spans 4 and 8) and fixes the carry-out.
- The fourth stage forms the sum bits.

The per-bit propagate signals travel alongside the prefix terms so that the last stage can use them.

A caller may present an operand pair with `in_valid` high on any cycle, including every cycle in a row. The result appears with `out_valid` high exactly four clock edges after the capture edge, counting the capture edge itself. Idle cycles in the input stream show up as idle cycles at the output with the same spacing. A synchronous reset empties the pipeline.

Top module: `pfx_pipe_adder`

## Requirements
- R1: When `out_valid` is high, `out_sum` equals the low WIDTH bits of the unsigned sum of the operand pair captured four edges earlier.
- R2: When `out_valid` is high, `out_cout` equals bit WIDTH (the bit above the top sum bit) of that same unsigned sum.
- R3: `out_valid` after clock edge k equals `in_valid` as sampled at edge k-3, provided no reset edge occurred from k-3 through k. The latency is therefore four edges, counting the capture edge.
- R4: Operand pairs presented on consecutive cycles produce correct results on consecutive cycles, so one add completes per cycle.
- R5: An edge with `rst` high empties the pipeline. After that edge `out_valid`, `out_sum` and `out_cout` are 0, and any operand pair that was in flight at that edge never produces a result.
- R6: There is no carry-in. 0 + 0 gives sum 0 and carry 0, and `out_sum[0]` is always `in_a[0]` XOR `in_b[0]`.
- R7: A carry generated at bit 0 reaches every bit. 0xFFFF + 0x0001 gives sum 0x0000 with carry 1, and 0x7FFF + 0x0001 gives 0x8000 with carry 0.
- R8: A cycle with `in_valid` low yields a cycle with `out_valid` low four edges later, and the results on either side of it are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair is valid this cycle |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| out_valid | output | 1 | Result is valid this cycle |
| out_sum | output | WIDTH | Sum modulo 2^WIDTH |
| out_cout | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach from the ports is a reset that lands while several adds are still in the pipeline. Those adds must disappear without a trace, and a new add entering right after the reset must still come out on time. The stimulus first fills all four stages with valid pairs, then asserts reset for one edge and immediately resumes issuing. The bench checks that exactly the flushed slots come out invalid and that the next result keeps the four-edge latency. Full-length carry propagation is reached with operands whose generate sits in bit 0 and whose propagate covers every bit above it, so the carry has to cross all prefix levels and both stage boundaries.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    localparam int PFX_WIDTH = 16;

    function automatic int pfx_levels(input int width);
        return $clog2(width);
    endfunction

endpackage

// File: rtl/pfx_bitgp.sv
module pfx_bitgp #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] g_o,
    output logic [WIDTH-1:0] p_o
);

    always_comb begin
        g_o = a_i & b_i;
        p_o = a_i ^ b_i;
    end

endmodule

// File: rtl/pfx_level.sv
module pfx_level #(
    parameter int WIDTH = 16,
    parameter int SPAN  = 1
) (
    input  logic [WIDTH-1:0] g_i,
    input  logic [WIDTH-1:0] p_i,
    output logic [WIDTH-1:0] g_o,
    output logic [WIDTH-1:0] p_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i >= SPAN) begin : g_dot
            assign g_o[i] = g_i[i] | (p_i[i] & g_i[i-SPAN]);
            assign p_o[i] = p_i[i] & p_i[i-SPAN];
        end else begin : g_pass
            assign g_o[i] = g_i[i];
            assign p_o[i] = p_i[i];
        end
    end

endmodule

// File: rtl/pfx_span_chain.sv
module pfx_span_chain #(
    parameter int WIDTH = 16,
    parameter int FIRST = 0,
    parameter int COUNT = 2
) (
    input  logic [WIDTH-1:0] g_i,
    input  logic [WIDTH-1:0] p_i,
    output logic [WIDTH-1:0] g_o,
    output logic [WIDTH-1:0] p_o
);

    logic [WIDTH-1:0] g_l [COUNT+1];
    logic [WIDTH-1:0] p_l [COUNT+1];

    assign g_l[0] = g_i;
    assign p_l[0] = p_i;

    for (genvar l = 0; l < COUNT; l++) begin : g_lvl
        pfx_level #(
            .WIDTH (WIDTH),
            .SPAN  (1 << (FIRST + l))
        ) u_level (
            .g_i (g_l[l]),
            .p_i (p_l[l]),
            .g_o (g_l[l+1]),
            .p_o (p_l[l+1])
        );
    end

    assign g_o = g_l[COUNT];
    assign p_o = p_l[COUNT];

endmodule

// File: rtl/pfx_sum.sv
module pfx_sum #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] pb_i,
    input  logic [WIDTH-2:0] cin_i,
    output logic [WIDTH-1:0] sum_o
);

    assign sum_o[0] = pb_i[0];

    for (genvar i = 1; i < WIDTH; i++) begin : g_sum
        assign sum_o[i] = pb_i[i] ^ cin_i[i-1];
    end

endmodule

// File: rtl/pfx_pipe_adder.sv
module pfx_pipe_adder
    import pfx_pkg::*;
#(
    parameter int WIDTH = PFX_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_sum,
    output logic             out_cout
);

    localparam int LEVELS = pfx_levels(WIDTH);
    localparam int SPLIT  = LEVELS / 2;
    localparam int UPPER  = LEVELS - SPLIT;

    typedef struct packed {
        logic             v;
        logic [WIDTH-1:0] g;
        logic [WIDTH-1:0] p;
    } st_bit_t;

    typedef struct packed {
        logic             v;
        logic [WIDTH-1:0] g;
        logic [WIDTH-1:0] p;
        logic [WIDTH-1:0] pb;
    } st_low_t;

    typedef struct packed {
        logic             v;
        logic [WIDTH-2:0] gc;
        logic [WIDTH-1:0] pb;
        logic             cout;
    } st_high_t;

    typedef struct packed {
        logic             v;
        logic [WIDTH-1:0] sum;
        logic             cout;
    } st_out_t;

    typedef struct packed {
        st_bit_t  s1;
        st_low_t  s2;
        st_high_t s3;
        st_out_t  s4;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [WIDTH-1:0] bit_g, bit_p;
    logic [WIDTH-1:0] low_g, low_p;
    logic [WIDTH-1:0] high_g, high_p_unused;
    logic [WIDTH-1:0] sum_w;

    pfx_bitgp #(.WIDTH(WIDTH)) u_bitgp (
        .a_i (in_a),
        .b_i (in_b),
        .g_o (bit_g),
        .p_o (bit_p)
    );

    pfx_span_chain #(
        .WIDTH (WIDTH),
        .FIRST (0),
        .COUNT (SPLIT)
    ) u_low_levels (
        .g_i (pipe_q.s1.g),
        .p_i (pipe_q.s1.p),
        .g_o (low_g),
        .p_o (low_p)
    );

    pfx_span_chain #(
        .WIDTH (WIDTH),
        .FIRST (SPLIT),
        .COUNT (UPPER)
    ) u_high_levels (
        .g_i (pipe_q.s2.g),
        .p_i (pipe_q.s2.p),
        .g_o (high_g),
        .p_o (high_p_unused)
    );

    pfx_sum #(.WIDTH(WIDTH)) u_sum (
        .pb_i  (pipe_q.s3.pb),
        .cin_i (pipe_q.s3.gc),
        .sum_o (sum_w)
    );

    always_comb begin
        pipe_d = pipe_q;

        pipe_d.s1.v    = in_valid;
        pipe_d.s1.g    = bit_g;
        pipe_d.s1.p    = bit_p;

        pipe_d.s2.v    = pipe_q.s1.v;
        pipe_d.s2.g    = low_g;
        pipe_d.s2.p    = low_p;
        pipe_d.s2.pb   = pipe_q.s1.p;

        pipe_d.s3.v    = pipe_q.s2.v;
        pipe_d.s3.gc   = high_g[WIDTH-2:0];
        pipe_d.s3.pb   = pipe_q.s2.pb;
        pipe_d.s3.cout = high_g[WIDTH-1];

        pipe_d.s4.v    = pipe_q.s3.v;
        pipe_d.s4.sum  = sum_w;
        pipe_d.s4.cout = pipe_q.s3.cout;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.s4.v;
    assign out_sum   = pipe_q.s4.sum;
    assign out_cout  = pipe_q.s4.cout;

endmodule

// File: rtl/pfx_pipe_adder_chk.sv
module pfx_pipe_adder_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [WIDTH-1:0] in_a,
    input logic [WIDTH-1:0] in_b,
    input logic             out_valid,
    input logic [WIDTH-1:0] out_sum,
    input logic             out_cout
);

    localparam int DEPTH = 4;

    logic             ref_v   [DEPTH];
    logic [WIDTH:0]   ref_s   [DEPTH];
    logic             ref_lsb [DEPTH];
    logic             armed = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b1;
            for (int i = 0; i < DEPTH; i++) begin
                ref_v[i]   <= 1'b0;
                ref_s[i]   <= '0;
                ref_lsb[i] <= 1'b0;
            end
        end else begin
            ref_v[0]   <= in_valid;
            ref_s[0]   <= {1'b0, in_a} + {1'b0, in_b};
            ref_lsb[0] <= in_a[0] ^ in_b[0];
            for (int i = 1; i < DEPTH; i++) begin
                ref_v[i]   <= ref_v[i-1];
                ref_s[i]   <= ref_s[i-1];
                ref_lsb[i] <= ref_lsb[i-1];
            end
        end
    end

    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (rst || !armed)
        out_valid |-> out_sum == ref_s[DEPTH-1][WIDTH-1:0]); // R1

    AST_COUT_MATCH: assert property (@(posedge clk) disable iff (rst || !armed)
        out_valid |-> out_cout == ref_s[DEPTH-1][WIDTH]); // R2

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst || !armed)
        out_valid == ref_v[DEPTH-1]); // R3

    AST_RESET_FLUSH: assert property (@(posedge clk) disable iff (!armed)
        rst |=> !out_valid && !out_cout && out_sum == '0); // R5

    AST_LSB_NO_CARRY_IN: assert property (@(posedge clk) disable iff (rst || !armed)
        out_valid |-> out_sum[0] == ref_lsb[DEPTH-1]); // R6

endmodule

bind pfx_pipe_adder pfx_pipe_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_sum   (out_sum),
    .out_cout  (out_cout)
);

// File: tb/pfx_pipe_adder_test.sv
`timescale 1ns/1ps
module pfx_pipe_adder_test;

    localparam int W     = 16;
    localparam int HSIZE = 256;
    localparam int NVEC  = 12;

    localparam logic [31:0] VEC [NVEC] = '{
        {16'h0000, 16'h0000},
        {16'h1234, 16'h4321},
        {16'hFFFF, 16'hFFFF},
        {16'h8000, 16'h8000},
        {16'h00FF, 16'h0001},
        {16'h7FFF, 16'h0001},
        {16'hAAAA, 16'h5555},
        {16'h5555, 16'h5555},
        {16'h0F0F, 16'hF0F1},
        {16'hFFFE, 16'h0001},
        {16'h1111, 16'hEEEF},
        {16'hDEAD, 16'hBEEF}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         out_valid;
    logic [W-1:0] out_sum;
    logic         out_cout;

    int checks = 0;
    int errors = 0;
    int n = 0;
    bit done = 1'b0;

    logic        hv   [HSIZE];
    logic [W:0]  hs   [HSIZE];
    string       htag [HSIZE];

    always #2.5 clk = ~clk;

    pfx_pipe_adder #(.WIDTH(W)) uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_sum   (out_sum),
        .out_cout  (out_cout)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // One clock: drive inputs, record the expectation, step past the edge,
    // then compare the output against the pair captured three edges earlier.
    task automatic tick(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic r, input string tag);
        in_valid = v;
        in_a     = a;
        in_b     = b;
        rst      = r;
        hv[n]    = v && !r;
        hs[n]    = {1'b0, a} + {1'b0, b};
        htag[n]  = tag;
        if (r) begin
            for (int k = 1; k <= 3; k++) begin
                if (n - k >= 0) hv[n-k] = 1'b0;
            end
        end
        @(posedge clk);
        #1;
        if (n >= 3) begin
            int j = n - 3;
            check(out_valid == hv[j], {"R3 valid ", htag[j]}, out_valid, hv[j]);
            if (hv[j]) begin
                check(out_sum == hs[j][W-1:0], {"R1 sum ", htag[j]}, out_sum, hs[j][W-1:0]);
                check(out_cout == hs[j][W], {"R2 cout ", htag[j]}, out_cout, hs[j][W]);
            end
        end else begin
            check(out_valid == 1'b0, "R5 valid after reset", out_valid, 0);
        end
        n++;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R5: reset state seen at the ports
        tick(1'b0, '0, '0, 1'b1, "reset");
        check(out_valid == 1'b0 && out_sum == '0 && out_cout == 1'b0,
              "R5 reset state", {out_valid, out_cout, out_sum}, 0);
        tick(1'b0, '0, '0, 1'b1, "reset");

        // R4: table streamed back to back, one pair per cycle
        for (int i = 0; i < NVEC; i++) begin
            tick(1'b1, VEC[i][31:16], VEC[i][15:0], 1'b0, "R4 stream");
        end

        // R6: no carry-in, LSB is plain XOR
        tick(1'b1, 16'h0000, 16'h0000, 1'b0, "R6 zero");
        tick(1'b1, 16'h0001, 16'h0000, 1'b0, "R6 lsb");
        tick(1'b1, 16'h0001, 16'h0001, 1'b0, "R6 lsb carry");

        // R7: full-length carry ripple
        tick(1'b1, 16'hFFFF, 16'h0001, 1'b0, "R7 ffff+1");
        tick(1'b1, 16'h0001, 16'hFFFF, 1'b0, "R7 1+ffff");
        tick(1'b1, 16'h7FFF, 16'h0001, 1'b0, "R7 7fff+1");

        // R8: bubbles interleaved with valid adds
        tick(1'b0, 16'hFFFF, 16'hFFFF, 1'b0, "R8 bubble");
        tick(1'b1, 16'h0F00, 16'h0100, 1'b0, "R8 between");
        tick(1'b0, 16'h1234, 16'h1234, 1'b0, "R8 bubble");
        tick(1'b0, 16'h0000, 16'h0001, 1'b0, "R8 bubble");
        tick(1'b1, 16'hC000, 16'h4000, 1'b0, "R8 after");

        // R5: reset with the pipeline full, then resume at once
        tick(1'b1, 16'h1111, 16'h2222, 1'b0, "R5 inflight");
        tick(1'b1, 16'h3333, 16'h4444, 1'b0, "R5 inflight");
        tick(1'b1, 16'h5555, 16'h6666, 1'b0, "R5 inflight");
        tick(1'b1, 16'h7777, 16'h8888, 1'b1, "R5 reset");
        tick(1'b1, 16'hFFFF, 16'h0001, 1'b0, "R5 resume");
        tick(1'b1, 16'h8000, 16'h7FFF, 1'b0, "R5 resume");

        for (int i = 0; i < 4; i++) begin
            tick(1'b0, '0, '0, 1'b0, "R8 drain");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule